// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider Controller

This block sits behind an external dual-modulus prescaler and turns it into a programmable divider. It is clocked by the prescaler output. Each division cycle lasts M prescaler periods. During the first A of those periods the block holds the modulus-control line high, so that the prescaler divides by N+1. For the rest of the cycle the line is low and the prescaler divides by N. The block raises a one-period pulse in the last period of every cycle. One cycle therefore spans M·N + A input periods, where N is 16 or 8 depending on the selected prescaler ratio.

The division setting arrives as a single packed frequency word whose binary value equals the wanted ratio. In the 16/17 ratio the low four bits hold the swallow count and the next fifteen bits hold the main count. In the 8/9 ratio the swallow field is only three bits wide, so the main count moves down by one bit and the top bit of the word is unused. The word and the ratio select are sampled only on the edge that starts a new cycle. A host can therefore change them at any moment, and a new frequency takes effect cleanly at the next cycle boundary. The sampled ratio select is also driven out, so the prescaler and the counter always agree on N.

Top module: `dual_mod_divider_ctrl`

## Requirements
- R1: Measured in prescaler input periods (N+1 for each period with mod_ctrl high, N otherwise), every complete division cycle spans M·N + A periods, using the effective M and A that were sampled for that cycle.
- R2: With ratio_half = 0 (16/17 ratio, N = 16), A = freq_word[3:0] and M = freq_word[18:4], so the cycle ratio equals the word value whenever A ≤ M and M ≥ 1.
- R3: With ratio_half = 1 (8/9 ratio, N = 8), A = freq_word[2:0] and M = freq_word[17:3]. freq_word[18] has no effect.
- R4: mod_ctrl is high for exactly the first A periods of each cycle and low for the remaining M − A periods.
- R5: If the decoded A is larger than M, the swallow count used is M.
- R6: A decoded M of zero is treated as M = 1.
- R7: div_pulse is high in the last period of each cycle and low in every other period. A cycle lasts M periods.
- R8: freq_word and ratio_half are sampled only on the clock edge that starts a cycle. Changes inside a cycle have no effect until the next cycle begins.
- R9: ratio_sel is the ratio_half value sampled for the current cycle (1 = 8/9, 0 = 16/17).
- R10: While rst_n is low, mod_ctrl, div_pulse and ratio_sel are all 0. The first rising clock edge with rst_n high starts a cycle from the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to pclk |
| freq_word | input | 19 | Packed frequency word (swallow and main count) |
| ratio_half | input | 1 | Prescaler ratio request: 0 = 16/17, 1 = 8/9 |
| mod_ctrl | output | 1 | Modulus control to the prescaler, 1 = divide by N+1 |
| ratio_sel | output | 1 | Prescaler ratio applied for the current cycle |
| div_pulse | output | 1 | One-period pulse in the last period of each cycle |

## Verification
The embedded properties assume three things. Reset is removed away from a pclk edge. freq_word and ratio_half are stable around each rising edge. The main-count field is at least as wide as the swallow field. The bench meets these assumptions by changing every input and rst_n only on the falling edge, and by keeping the default field widths. Within those limits, the stimulus deliberately moves the word and the ratio select in the middle of a cycle, and it includes words with A > M, words with M = 0, and 8/9 words with the unused top bit set. Under all of these, the cycle-boundary sampling and the clamping must still hold.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

  // Default field widths of the packed frequency word.
  localparam int DEF_A_W = 4;
  localparam int DEF_M_W = 15;

  // Prescaler ratio encoding as seen on ratio_half / ratio_sel.
  typedef enum logic {
    PS_16_17 = 1'b0,
    PS_8_9   = 1'b1
  } ps_mode_e;

endpackage

// File: rtl/dmd_field_split.sv
// Splits the packed frequency word into effective swallow / main counts.
module dmd_field_split
  import dmd_pkg::*;
#(
  parameter int A_W = DEF_A_W,
  parameter int M_W = DEF_M_W
) (
  input  logic [A_W+M_W-1:0] word_i,
  input  logic               mode_i,
  output logic [M_W-1:0]     m_eff_o,
  output logic [A_W-1:0]     a_eff_o
);

  localparam int W_W = A_W + M_W;

  logic [A_W-1:0] a_raw;
  logic [M_W-1:0] m_raw;
  logic [M_W-1:0] m_nz;
  logic [M_W-1:0] a_ext;

  always_comb begin
    if (ps_mode_e'(mode_i) == PS_8_9) begin
      // Narrow swallow field: main count shifts down by one bit.
      a_raw = {1'b0, word_i[A_W-2:0]};
      m_raw = word_i[W_W-2:A_W-1];
    end else begin
      a_raw = word_i[A_W-1:0];
      m_raw = word_i[W_W-1:A_W];
    end
    m_nz    = (m_raw == '0) ? M_W'(1) : m_raw;
    a_ext   = M_W'(a_raw);
    a_eff_o = (a_ext > m_nz) ? m_nz[A_W-1:0] : a_raw;
    m_eff_o = m_nz;
  end

endmodule

// File: rtl/dmd_cycle_count.sv
// Main (M) down-counter: marks cycle boundaries and the terminal period.
module dmd_cycle_count #(
  parameter int M_W = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_eff_i,
  output logic           load_o,
  output logic [M_W-1:0] m_cnt_o,
  output logic           pulse_o,
  output logic           run_o
);

  logic           run_q;
  logic [M_W-1:0] m_cnt_q, m_cnt_d;
  logic           pulse_q, pulse_d;
  logic           load;

  always_comb begin
    load    = !run_q || (m_cnt_q == '0);
    m_cnt_d = load ? (m_eff_i - M_W'(1)) : (m_cnt_q - M_W'(1));
    pulse_d = (m_cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      m_cnt_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      run_q   <= 1'b1;
      m_cnt_q <= m_cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign load_o  = load;
  assign m_cnt_o = m_cnt_q;
  assign pulse_o = pulse_q;
  assign run_o   = run_q;

  // R7: between boundaries the count steps down by exactly one
  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && m_cnt_q != '0) |=> (m_cnt_q == $past(m_cnt_q) - M_W'(1)));

  // R7: the pulse marks the terminal period and only that period
  p_pulse_term_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (pulse_q == (m_cnt_q == '0)));

endmodule

// File: rtl/dmd_swallow.sv
// Swallow (A) counter: holds the modulus line high for A periods per cycle.
module dmd_swallow #(
  parameter int A_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [A_W-1:0] a_eff_i,
  output logic [A_W-1:0] a_cnt_o,
  output logic           mod_o
);

  logic [A_W-1:0] a_cnt_q, a_cnt_d;
  logic           mod_q, mod_d;

  always_comb begin
    if (load_i)
      a_cnt_d = a_eff_i;
    else if (a_cnt_q != '0)
      a_cnt_d = a_cnt_q - A_W'(1);
    else
      a_cnt_d = '0;
    mod_d = (a_cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt_q <= '0;
      mod_q   <= 1'b0;
    end else begin
      a_cnt_q <= a_cnt_d;
      mod_q   <= mod_d;
    end
  end

  assign a_cnt_o = a_cnt_q;
  assign mod_o   = mod_q;

  // R4: the modulus line can only rise at the start of a cycle
  p_mod_rise_at_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_q) |-> $past(load_i));

endmodule

// File: rtl/dual_mod_divider_ctrl.sv
module dual_mod_divider_ctrl
  import dmd_pkg::*;
#(
  parameter int A_W = DEF_A_W,
  parameter int M_W = DEF_M_W
) (
  input  logic               pclk,
  input  logic               rst_n,
  input  logic [A_W+M_W-1:0] freq_word,
  input  logic               ratio_half,
  output logic               mod_ctrl,
  output logic               ratio_sel,
  output logic               div_pulse
);

  localparam int E_W = M_W + 1;

  logic [M_W-1:0] m_eff;
  logic [A_W-1:0] a_eff;
  logic           load;
  logic [M_W-1:0] m_cnt;
  logic [A_W-1:0] a_cnt;
  logic           run;
  logic           sel_q, sel_d;

  dmd_field_split #(.A_W(A_W), .M_W(M_W)) split_i (
    .word_i  (freq_word),
    .mode_i  (ratio_half),
    .m_eff_o (m_eff),
    .a_eff_o (a_eff)
  );

  dmd_cycle_count #(.M_W(M_W)) cyc_i (
    .clk     (pclk),
    .rst_n   (rst_n),
    .m_eff_i (m_eff),
    .load_o  (load),
    .m_cnt_o (m_cnt),
    .pulse_o (div_pulse),
    .run_o   (run)
  );

  dmd_swallow #(.A_W(A_W)) swl_i (
    .clk     (pclk),
    .rst_n   (rst_n),
    .load_i  (load),
    .a_eff_i (a_eff),
    .a_cnt_o (a_cnt),
    .mod_o   (mod_ctrl)
  );

  // Ratio select register, enabled only on a cycle boundary.
  always_comb begin
    sel_d = sel_q;
    if (load) sel_d = ratio_half;
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  assign ratio_sel = sel_q;

  logic [E_W-1:0] a_wide, m_wide;
  assign a_wide = E_W'(a_cnt);
  assign m_wide = E_W'(m_cnt);

  // R5: remaining swallow periods never exceed remaining cycle periods
  p_swallow_fits_r5: assert property (@(posedge pclk) disable iff (!rst_n)
    run |-> (a_wide <= m_wide + E_W'(1)));

  // R8: applied ratio holds for the whole cycle
  p_sel_hold_r8: assert property (@(posedge pclk) disable iff (!rst_n)
    !$past(load) |-> $stable(sel_q));

endmodule

// File: tb/dual_mod_divider_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_mod_divider_ctrl_tb_top;

  logic        pclk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] freq_word = '0;
  logic        ratio_half = 1'b0;
  logic        mod_ctrl, ratio_sel, div_pulse;

  int checks = 0;
  int failures = 0;
  string cur_tag = "R10";

  always #2.5 pclk = ~pclk;

  dual_mod_divider_ctrl dut_i (
    .pclk       (pclk),
    .rst_n      (rst_n),
    .freq_word  (freq_word),
    .ratio_half (ratio_half),
    .mod_ctrl   (mod_ctrl),
    .ratio_sel  (ratio_sel),
    .div_pulse  (div_pulse)
  );

  // Behavioural reference: position within the cycle, counted upward.
  bit started = 0;
  int pos = 0, m_cur = 1, a_cur = 0, ratio_cur = 0, acc = 0;
  bit half_cur = 0;

  task automatic decode(input logic [18:0] w, input logic h);
    int n, a, m;
    n = h ? 8 : 16;
    a = h ? (w % 8) : (w % 16);
    m = h ? ((w / 8) % 32768) : (w / 16);
    if (m == 0) m = 1;
    if (a > m) a = m;
    m_cur = m; a_cur = a; half_cur = h;
    ratio_cur = m * n + a;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s [%s] %s: actual=%0d expected=%0d", req, cur_tag, what, act, exp);
    end
  endtask

  always @(posedge pclk) begin
    if (!rst_n) begin
      started = 0; acc = 0;
    end else if (!started || pos == m_cur - 1) begin
      decode(freq_word, ratio_half);
      pos = 0; started = 1;
    end else begin
      pos++;
    end
    #1;
    chk("R4", "mod_ctrl", int'(mod_ctrl), int'(started && pos < a_cur));
    chk("R7", "div_pulse", int'(div_pulse), int'(started && pos == m_cur - 1));
    chk("R9", "ratio_sel", int'(ratio_sel), int'(started && half_cur));
    if (started) begin
      acc += (ratio_sel ? 8 : 16) + (mod_ctrl ? 1 : 0);
      if (div_pulse === 1'b1) begin
        chk("R1", "cycle ratio", acc, ratio_cur);
        acc = 0;
      end
    end
  end

  task automatic drive(input logic [18:0] w, input logic h, input string tag);
    @(negedge pclk);
    freq_word = w; ratio_half = h; cur_tag = tag;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge pclk);
  endtask

  initial begin
    freq_word = 19'd83;
    wait_n(3);
    // R10: outputs idle under reset
    chk("R10", "reset mod_ctrl", int'(mod_ctrl), 0);
    chk("R10", "reset div_pulse", int'(div_pulse), 0);
    chk("R10", "reset ratio_sel", int'(ratio_sel), 0);
    rst_n = 1'b1;
    wait_n(20);
    // R2: 16/17 words, ratio equals word
    drive(19'd112, 1'b0, "R2");     wait_n(25);
    drive(19'd335, 1'b0, "R2");     wait_n(70);
    // R3: 8/9 words, top bit set must be ignored
    drive((19'd1 << 18) | 19'd53, 1'b1, "R3"); wait_n(30);
    drive(19'd79, 1'b1, "R3");      wait_n(30);
    // R5: A larger than M
    drive(19'd60, 1'b0, "R5");      wait_n(15);
    drive(19'd23, 1'b1, "R5");      wait_n(15);
    // R6: M field zero
    drive(19'd10, 1'b0, "R6");      wait_n(6);
    drive(19'd5, 1'b1, "R6");       wait_n(6);
    // R8: changes inside a cycle take effect only at the boundary
    drive(19'd150, 1'b0, "R8");     wait_n(4);
    drive(19'd99, 1'b1, "R8");      wait_n(3);
    drive(19'd200, 1'b0, "R8");     wait_n(5);
    drive(19'd41, 1'b1, "R8");      wait_n(40);
    // R10: reset in mid-cycle, then restart from current inputs
    @(negedge pclk); rst_n = 1'b0; cur_tag = "R10";
    wait_n(1);
    chk("R10", "mid reset mod_ctrl", int'(mod_ctrl), 0);
    chk("R10", "mid reset div_pulse", int'(div_pulse), 0);
    chk("R10", "mid reset ratio_sel", int'(ratio_sel), 0);
    freq_word = 19'd37; ratio_half = 1'b1;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(20);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge pclk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule